// File: doc/BRIEF.md
# Power-register access command sequencer

This block accepts one request at a time to read, write or bit-update up to five registers behind a mailbox, and converts it into the sequence of register-bus accesses that the mailbox expects. A request names an operation, an item count, a list of 16-bit register addresses and a list of data bytes. The sequencer validates the request and checks that the mailbox is idle. It loads the outbound buffer with the packed payload and writes a command word whose size field depends on the operation. It then polls the mailbox status at a fixed spacing until the busy flag clears or a cycle budget runs out.

The result comes back as a one-cycle response carrying an error code and, for reads, the reply bytes. The mailbox sits on a simple request/acknowledge register bus. The sequencer is the only master on that bus. Mailbox offsets are 0x00 for the command word, 0x04 for status (bit 0 busy, bit 1 error), 0x80 upward for the outbound buffer and 0x90 upward for the inbound buffer.

Top module: `pwr_reg_seq`

## Requirements
- R1: The command word is written to offset 0x00 and carries 0xFF in bits 7:0, a 1 in bit 8, the sub-type in bits 15:12 (0 write, 1 read, 2 update), the size in bits 23:16 and zeros elsewhere.
- R2: Every issued request writes all BUF_WORDS outbound words in ascending order at 0x80, 0x84, ... before the command word. Addresses are packed little-endian from byte 0, and bytes past the payload are zero.
- R3: A write (req_op 0) places data byte i at outbound byte 2n+i for an n-item request, and the size is 3n.
- R4: A read (req_op 1) sends only addresses with size 2n. On success it reads ceil(n/4) inbound words from 0x90 upward and returns inbound byte i as rsp_data byte i for i < n.
- R5: An update (req_op 2) needs a count of 1. It sends address item 0 in bytes 0-1, the value (req_data byte 0) in byte 2 and the mask (req_data byte 1, 1 = bit changes) in byte 3, with size 4.
- R6: A count of 0 or above MAX_ITEMS, req_op 3, or an update with a count other than 1 returns error 4 (invalid) with no bus access at all.
- R7: The first bus access of a valid request is a status read at 0x04. If status bit 0 is set, the request ends with error 1 (busy) and makes no write.
- R8: After the command, status is re-read with at least POLL_GAP cycles between reads. Busy clear with bit 1 set gives error 3 (I/O); busy clear with bit 1 clear gives error 0.
- R9: If status still shows busy at a poll taken TIMEOUT_CYC or more cycles after the command, the request ends with error 2 (timeout).
- R10: req_ready is high only while no request is in flight. rsp_valid is a single-cycle pulse. rsp_data is zero except for the reply bytes of a successful read.
- R11: Once raised, bus_req stays high with bus_we, bus_addr and bus_wdata unchanged until the cycle after bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_op | input | 2 | 0 write, 1 read, 2 masked update, 3 reserved |
| req_count | input | CNT_W | Number of items |
| req_addr | input | 16*MAX_ITEMS | Register addresses, item i at bits 16i+15:16i |
| req_data | input | 8*MAX_ITEMS | Data bytes, byte i at bits 8i+7:8i |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 3 | 0 ok, 1 busy, 2 timeout, 3 I/O, 4 invalid |
| rsp_data | output | 8*MAX_ITEMS | Reply bytes of a read |
| bus_req | output | 1 | Register bus access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 8 | Mailbox byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
A wrong phase or index register shows first on the register bus. A missing, repeated or reordered buffer word, or a malformed command word, is visible within the access that carries it. The bench checks every write against payload bytes it computes from the request on its own. A wrong poll counter shows as status reads spaced too closely, or as a timeout response outside the window set by TIMEOUT_CYC and POLL_GAP. A wrong capture index shows in the reply bytes of the one-cycle response.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_READ  = 2'd1,
      OP_RMW   = 2'd2,
      OP_RSVD  = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      ERR_OK      = 3'd0,
      ERR_BUSY    = 3'd1,
      ERR_TIMEOUT = 3'd2,
      ERR_IO      = 3'd3,
      ERR_INVAL   = 3'd4
   } err_e;

   localparam logic [7:0] MSG_PWR  = 8'hFF;
   localparam logic [7:0] OFS_CMD  = 8'h00;
   localparam logic [7:0] OFS_STAT = 8'h04;
   localparam logic [7:0] OFS_OUT  = 8'h80;
   localparam logic [7:0] OFS_IN   = 8'h90;
   localparam int STAT_BUSY   = 0;
   localparam int STAT_ERR    = 1;
   localparam int CMD_IOC_BIT = 8;

   function automatic logic [31:0] make_cmd(input logic [1:0] sub, input logic [7:0] size);
      return {8'h00, size, 2'b00, sub, 3'b000, 1'b1, MSG_PWR};
   endfunction

endpackage

// File: rtl/pwr_seq_pack.sv
module pwr_seq_pack
   import pwr_seq_pkg::*;
#(
   parameter int MAX_ITEMS = 5,
   parameter int BUF_WORDS = 4,
   parameter int CNT_W     = 3
) (
   input  logic [1:0]               op,
   input  logic [CNT_W-1:0]         count,
   input  logic [MAX_ITEMS*16-1:0]  addr_flat,
   input  logic [MAX_ITEMS*8-1:0]   data_flat,
   output logic [BUF_WORDS*32-1:0]  obuf,
   output logic [7:0]               size,
   output logic                     ok
);
   localparam int NBYTES = 4 * BUF_WORDS;

   int n;
   assign n = int'(count);

   always_comb begin
      ok = (op != OP_RSVD) && (n >= 1) && (n <= MAX_ITEMS) && ((op != OP_RMW) || (n == 1));
      case (op)
         OP_WRITE: size = 8'(3 * n);
         OP_READ:  size = 8'(2 * n);
         default:  size = 8'd4;
      endcase
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      logic [7:0] abyte;
      logic [7:0] lane;
      assign abyte = 8'(addr_flat >> (8 * b));
      always_comb begin
         lane = 8'h00;
         if (op == OP_RMW) begin
            if (b < 2)       lane = abyte;
            else if (b == 2) lane = data_flat[7:0];
            else if (b == 3) lane = data_flat[15:8];
         end else if (b < 2 * n) begin
            lane = abyte;
         end else if ((op == OP_WRITE) && (b < 3 * n)) begin
            lane = 8'(data_flat >> (8 * (b - 2 * n)));
         end
      end
      assign obuf[8*b +: 8] = lane;
   end

endmodule

// File: rtl/pwr_seq_bus.sv
module pwr_seq_bus (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        we,
   input  logic [7:0]  addr,
   input  logic [31:0] wdata,
   output logic        done,
   output logic [31:0] rdata,
   output logic        bus_req,
   output logic        bus_we,
   output logic [7:0]  bus_addr,
   output logic [31:0] bus_wdata,
   input  logic        bus_ack,
   input  logic [31:0] bus_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_req   <= 1'b0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         done      <= 1'b0;
         rdata     <= '0;
      end else begin
         done <= 1'b0;
         if (bus_req) begin
            if (bus_ack) begin
               bus_req <= 1'b0;
               done    <= 1'b1;
               rdata   <= bus_rdata;
            end
         end else if (start) begin
            bus_req   <= 1'b1;
            bus_we    <= we;
            bus_addr  <= addr;
            bus_wdata <= wdata;
         end
      end
   end

   assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int MAX_ITEMS   = 5,
   parameter int BUF_WORDS   = 4,
   parameter int CNT_W       = 3,
   parameter int POLL_GAP    = 4,
   parameter int TIMEOUT_CYC = 200
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [1:0]               req_op,
   input  logic [CNT_W-1:0]         req_count,
   input  logic [BUF_WORDS*32-1:0]  pk_obuf,
   input  logic [7:0]               pk_size,
   input  logic                     pk_ok,
   output logic                     rsp_valid,
   output logic [2:0]               rsp_err,
   output logic [MAX_ITEMS*8-1:0]   rsp_data,
   output logic                     bus_start,
   output logic                     bus_wr,
   output logic [7:0]               bus_ofs,
   output logic [31:0]              bus_wd,
   input  logic                     bus_done,
   input  logic [31:0]              bus_rd
);
   localparam int RD_WORDS = (MAX_ITEMS + 3) / 4;
   localparam int EL_W     = $clog2(TIMEOUT_CYC + 1);
   localparam int GAP_W    = $clog2(POLL_GAP + 1);
   localparam int WI_W     = $clog2(BUF_WORDS + 1);
   localparam int RI_W     = $clog2(RD_WORDS + 1);

   typedef enum logic [3:0] {
      S_IDLE, S_PRE, S_PRE_W, S_BUF, S_BUF_W, S_CMD, S_CMD_W,
      S_GAP, S_POLL, S_POLL_W, S_RD, S_RD_W, S_RESP
   } state_e;

   state_e                   state;
   logic [1:0]               op_q;
   logic [CNT_W-1:0]         cnt_q;
   logic [BUF_WORDS*32-1:0]  obuf_q;
   logic [7:0]               size_q;
   logic [2:0]               err_q;
   logic [RD_WORDS*32-1:0]   rbuf_q;
   logic [WI_W-1:0]          widx;
   logic [RI_W-1:0]          ridx;
   logic [GAP_W-1:0]         gap;
   logic [EL_W-1:0]          elapsed;
   logic                     cmd_sent;
   logic [WI_W-1:0]          buf_cnt;
   logic [CNT_W:0]           rd_words;

   assign rd_words  = ({1'b0, cnt_q} + (CNT_W+1)'(3)) >> 2;
   assign req_ready = (state == S_IDLE);
   assign rsp_valid = (state == S_RESP);
   assign rsp_err   = err_q;
   assign rsp_data  = rbuf_q[MAX_ITEMS*8-1:0];

   always_comb begin
      bus_start = 1'b0;
      bus_wr    = 1'b0;
      bus_ofs   = OFS_STAT;
      bus_wd    = '0;
      case (state)
         S_PRE, S_POLL: bus_start = 1'b1;
         S_BUF: begin
            bus_start = 1'b1;
            bus_wr    = 1'b1;
            bus_ofs   = 8'(int'(OFS_OUT) + 4 * int'(widx));
            bus_wd    = obuf_q[32*widx +: 32];
         end
         S_CMD: begin
            bus_start = 1'b1;
            bus_wr    = 1'b1;
            bus_ofs   = OFS_CMD;
            bus_wd    = make_cmd(op_q, size_q);
         end
         S_RD: begin
            bus_start = 1'b1;
            bus_ofs   = 8'(int'(OFS_IN) + 4 * int'(ridx));
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         op_q     <= '0;
         cnt_q    <= '0;
         obuf_q   <= '0;
         size_q   <= '0;
         err_q    <= ERR_OK;
         rbuf_q   <= '0;
         widx     <= '0;
         ridx     <= '0;
         gap      <= '0;
         elapsed  <= '0;
         cmd_sent <= 1'b0;
         buf_cnt  <= '0;
      end else begin
         if ((state == S_GAP || state == S_POLL || state == S_POLL_W) &&
             (elapsed < EL_W'(TIMEOUT_CYC)))
            elapsed <= elapsed + 1'b1;
         case (state)
            S_IDLE: if (req_valid) begin
               op_q     <= req_op;
               cnt_q    <= req_count;
               obuf_q   <= pk_obuf;
               size_q   <= pk_size;
               rbuf_q   <= '0;
               cmd_sent <= 1'b0;
               buf_cnt  <= '0;
               err_q    <= pk_ok ? ERR_OK : ERR_INVAL;
               state    <= pk_ok ? S_PRE : S_RESP;
            end
            S_PRE:  state <= S_PRE_W;
            S_PRE_W: if (bus_done) begin
               if (bus_rd[STAT_BUSY]) begin
                  err_q <= ERR_BUSY;
                  state <= S_RESP;
               end else begin
                  widx  <= '0;
                  state <= S_BUF;
               end
            end
            S_BUF:  state <= S_BUF_W;
            S_BUF_W: if (bus_done) begin
               buf_cnt <= buf_cnt + 1'b1;
               if (widx == WI_W'(BUF_WORDS - 1)) state <= S_CMD;
               else begin
                  widx  <= widx + 1'b1;
                  state <= S_BUF;
               end
            end
            S_CMD: begin
               cmd_sent <= 1'b1;
               state    <= S_CMD_W;
            end
            S_CMD_W: if (bus_done) begin
               elapsed <= '0;
               gap     <= '0;
               state   <= S_GAP;
            end
            S_GAP: begin
               if (gap == GAP_W'(POLL_GAP - 1)) state <= S_POLL;
               else gap <= gap + 1'b1;
            end
            S_POLL: state <= S_POLL_W;
            S_POLL_W: if (bus_done) begin
               if (!bus_rd[STAT_BUSY]) begin
                  if (bus_rd[STAT_ERR]) begin
                     err_q <= ERR_IO;
                     state <= S_RESP;
                  end else if (op_q == OP_READ) begin
                     ridx  <= '0;
                     state <= S_RD;
                  end else begin
                     state <= S_RESP;
                  end
               end else if (elapsed >= EL_W'(TIMEOUT_CYC)) begin
                  err_q <= ERR_TIMEOUT;
                  state <= S_RESP;
               end else begin
                  gap   <= '0;
                  state <= S_GAP;
               end
            end
            S_RD: state <= S_RD_W;
            S_RD_W: if (bus_done) begin
               for (int k = 0; k < 4; k++) begin
                  if (int'(ridx) * 4 + k < int'(cnt_q))
                     rbuf_q[32*ridx + 8*k +: 8] <= bus_rd[8*k +: 8];
               end
               if ({{(CNT_W+1-RI_W){1'b0}}, ridx} == rd_words - 1'b1) state <= S_RESP;
               else begin
                  ridx  <= ridx + 1'b1;
                  state <= S_RD;
               end
            end
            S_RESP: state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assert_cmd_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start && bus_wr && bus_ofs == OFS_CMD) |->
      (cnt_q != '0) && (int'(cnt_q) <= MAX_ITEMS) && (op_q != OP_RSVD));

   assert_buf_before_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start && bus_wr && bus_ofs == OFS_CMD) |-> (buf_cnt == WI_W'(BUF_WORDS)));

   assert_busy_no_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err == ERR_BUSY) |-> !cmd_sent);

   assert_timeout_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err == ERR_TIMEOUT) |-> (elapsed >= EL_W'(TIMEOUT_CYC)));

   assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/pwr_reg_seq.sv
module pwr_reg_seq
   import pwr_seq_pkg::*;
#(
   parameter int MAX_ITEMS   = 5,
   parameter int BUF_WORDS   = 4,
   parameter int CNT_W       = 3,
   parameter int POLL_GAP    = 4,
   parameter int TIMEOUT_CYC = 200
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [1:0]               req_op,
   input  logic [CNT_W-1:0]         req_count,
   input  logic [MAX_ITEMS*16-1:0]  req_addr,
   input  logic [MAX_ITEMS*8-1:0]   req_data,
   output logic                     rsp_valid,
   output logic [2:0]               rsp_err,
   output logic [MAX_ITEMS*8-1:0]   rsp_data,
   output logic                     bus_req,
   output logic                     bus_we,
   output logic [7:0]               bus_addr,
   output logic [31:0]              bus_wdata,
   input  logic                     bus_ack,
   input  logic [31:0]              bus_rdata
);

   if (MAX_ITEMS < 2 || 3 * MAX_ITEMS > 4 * BUF_WORDS) begin : g_bad_items
      $error("item count does not fit the outbound buffer");
   end
   if (BUF_WORDS > 4) begin : g_bad_buf
      $error("outbound buffer would overlap the inbound buffer");
   end
   if (MAX_ITEMS >= (1 << CNT_W)) begin : g_bad_cnt
      $error("count width cannot express an over-limit count");
   end
   if (POLL_GAP < 1 || TIMEOUT_CYC < 1) begin : g_bad_time
      $error("poll spacing and timeout must be positive");
   end

   logic [BUF_WORDS*32-1:0] pk_obuf;
   logic [7:0]              pk_size;
   logic                    pk_ok;
   logic                    bus_start, bus_wr, bus_done;
   logic [7:0]              bus_ofs;
   logic [31:0]             bus_wd, bus_rd;

   pwr_seq_pack #(.MAX_ITEMS(MAX_ITEMS), .BUF_WORDS(BUF_WORDS), .CNT_W(CNT_W)) u_pack (
      .op(req_op), .count(req_count), .addr_flat(req_addr), .data_flat(req_data),
      .obuf(pk_obuf), .size(pk_size), .ok(pk_ok)
   );

   pwr_seq_ctrl #(.MAX_ITEMS(MAX_ITEMS), .BUF_WORDS(BUF_WORDS), .CNT_W(CNT_W),
                  .POLL_GAP(POLL_GAP), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_count(req_count), .pk_obuf(pk_obuf), .pk_size(pk_size),
      .pk_ok(pk_ok), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
      .bus_start(bus_start), .bus_wr(bus_wr), .bus_ofs(bus_ofs), .bus_wd(bus_wd),
      .bus_done(bus_done), .bus_rd(bus_rd)
   );

   pwr_seq_bus u_bus (
      .clk(clk), .rst_n(rst_n), .start(bus_start), .we(bus_wr), .addr(bus_ofs),
      .wdata(bus_wd), .done(bus_done), .rdata(bus_rd), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   assert_cmd_format_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == OFS_CMD) |->
      (bus_wdata[CMD_IOC_BIT] && bus_wdata[7:0] == MSG_PWR && bus_wdata[31:24] == 8'h00));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !bus_req);

endmodule

// File: tb/pwr_reg_seq_tb.sv
module pwr_reg_seq_tb;
   localparam int MAXI = 5;
   localparam int PG   = 4;
   localparam int TO   = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = '0;
   logic [2:0]  req_count = '0;
   logic [79:0] req_addr = '0;
   logic [39:0] req_data = '0;
   logic        rsp_valid;
   logic [2:0]  rsp_err;
   logic [39:0] rsp_data;
   logic        bus_req, bus_we, bus_ack;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;

   always #4 clk = ~clk;

   pwr_reg_seq #(.MAX_ITEMS(MAXI), .BUF_WORDS(4), .CNT_W(3), .POLL_GAP(PG), .TIMEOUT_CYC(TO)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_count(req_count), .req_addr(req_addr), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   // mailbox model
   int          cyc = 0;
   int          busy_cnt = 0;
   int          busy_len = 10;
   bit          pre_busy = 0;
   bit          err_flag = 0;
   logic [31:0] inb0 = 32'h44332211;
   logic [31:0] inb1 = 32'h88776655;
   int          cmd_cyc = 0;
   int          stat_cyc[$];
   logic [40:0] txq[$];

   always @(posedge clk) begin
      cyc++;
      if (busy_cnt > 0) busy_cnt--;
      if (bus_req && !bus_ack) begin
         bus_ack <= 1'b1;
         txq.push_back({bus_we, bus_addr, bus_wdata});
         if (bus_we && bus_addr == 8'h00) begin
            busy_cnt = busy_len;
            cmd_cyc  = cyc;
         end
         if (!bus_we) begin
            case (bus_addr)
               8'h04: begin
                  bus_rdata <= {30'd0, err_flag, (pre_busy || busy_cnt > 0)};
                  stat_cyc.push_back(cyc);
               end
               8'h90: bus_rdata <= inb0;
               8'h94: bus_rdata <= inb1;
               default: bus_rdata <= 32'h0;
            endcase
         end
      end else begin
         bus_ack <= 1'b0;
      end
   end

   // per-clock protocol comparison
   logic        p_req = 0, p_ack = 0, p_we = 0;
   logic [7:0]  p_addr = 0;
   logic [31:0] p_wd = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (p_req && !p_ack)
            chk(bus_req && bus_addr == p_addr && bus_wdata == p_wd && bus_we == p_we,
                "R11 bus hold", {bus_req, bus_addr, bus_wdata}, {1'b1, p_addr, p_wd});
         if (rsp_valid || bus_req)
            chk(!req_ready, "R10 ready low in flight", req_ready, 0);
      end
      p_req = bus_req; p_ack = bus_ack; p_we = bus_we; p_addr = bus_addr; p_wd = bus_wdata;
   end

   function automatic logic [127:0] exp_obuf(input int op, input int n, input logic [79:0] a, input logic [39:0] d);
      logic [127:0] r = '0;
      if (op == 2) begin
         r[15:0]  = a[15:0];
         r[23:16] = d[7:0];
         r[31:24] = d[15:8];
      end else begin
         for (int i = 0; i < n; i++) r[16*i +: 16] = a[16*i +: 16];
         if (op == 0) for (int i = 0; i < n; i++) r[8*(2*n+i) +: 8] = d[8*i +: 8];
      end
      return r;
   endfunction

   logic [2:0]  got_err;
   logic [39:0] got_data;
   int          rsp_cyc;
   bit          rsp_seen;

   task automatic do_req(input int op, input int n, input logic [79:0] a, input logic [39:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      txq.delete();
      stat_cyc.delete();
      req_op = 2'(op); req_count = 3'(n); req_addr = a; req_data = d;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      rsp_seen = 0;
      for (int t = 0; t < 2000 && !rsp_seen; t++) begin
         if (rsp_valid) begin
            rsp_seen = 1;
            got_err  = rsp_err;
            got_data = rsp_data;
            rsp_cyc  = cyc;
         end else @(negedge clk);
      end
      @(negedge clk);
      chk(!rsp_valid, "R10 single-cycle response", rsp_valid, 0);
   endtask

   task automatic run_case(input string r, input int op, input int n, input logic [79:0] a,
                           input logic [39:0] d, input int exp_err, input logic [39:0] exp_data);
      logic [127:0] ob;
      logic [40:0]  wr[$];
      int           rd_in;
      int           sz;
      logic [31:0]  ecmd;
      do_req(op, n, a, d);
      chk(rsp_seen, {r, " response seen"}, rsp_seen, 1);
      chk(got_err == 3'(exp_err), {r, " error code"}, got_err, exp_err);
      chk(got_data == exp_data, {r, " reply data"}, got_data, exp_data);
      if (exp_err == 4) begin
         chk(txq.size() == 0, {r, " no bus access"}, txq.size(), 0);
      end else if (exp_err == 1) begin
         chk(txq.size() == 1 && txq[0] == {1'b0, 8'h04, 32'h0} , {r, " single status read"},
             txq.size() > 0 ? txq[0] : 0, {1'b0, 8'h04, 32'h0});
      end else begin
         chk(txq.size() > 0 && txq[0][40:32] == {1'b0, 8'h04}, {r, " status read first"},
             txq.size() > 0 ? txq[0][40:32] : 0, 9'h004);
         rd_in = 0;
         foreach (txq[i]) begin
            if (txq[i][40]) wr.push_back(txq[i]);
            else if (txq[i][39:32] >= 8'h90) rd_in++;
         end
         ob = exp_obuf(op, n, a, d);
         sz = (op == 0) ? 3 * n : (op == 1) ? 2 * n : 4;
         ecmd = (32'(sz) << 16) | (32'(op) << 12) | 32'h0000_01FF;
         chk(wr.size() == 5, {r, " write count"}, wr.size(), 5);
         if (wr.size() == 5) begin
            for (int w = 0; w < 4; w++)
               chk(wr[w] == {1'b1, 8'(8'h80 + 4 * w), ob[32*w +: 32]}, {r, " R2 buffer word"},
                   wr[w], {1'b1, 8'(8'h80 + 4 * w), ob[32*w +: 32]});
            chk(wr[4] == {1'b1, 8'h00, ecmd}, {r, " R1 command word"}, wr[4], {1'b1, 8'h00, ecmd});
         end
         chk(rd_in == ((op == 1 && exp_err == 0) ? (n + 3) / 4 : 0), {r, " inbound reads"},
             rd_in, (op == 1 && exp_err == 0) ? (n + 3) / 4 : 0);
      end
   endtask

   initial begin
      bus_ack   = 1'b0;
      bus_rdata = '0;
      repeat (5) @(negedge clk);
      chk(req_ready == 1 && rsp_valid == 0 && bus_req == 0, "R10 reset state",
          {req_ready, rsp_valid, bus_req}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);

      run_case("R3 write one", 0, 1, 80'h1234, 40'h56, 0, 40'h0);
      run_case("R3 write five", 0, 5, 80'h5005_4004_3003_2002_1001, 40'hEE_DD_CC_BB_AA, 0, 40'h0);
      run_case("R4 read three", 1, 3, 80'h0C0C_0B0B_0A0A, 40'hFF_FF_FF_FF_FF, 0, 40'h00_0033_2211);
      run_case("R4 read five", 1, 5, 80'h0005_0004_0003_0002_0001, 40'h0, 0, 40'h55_4433_2211);
      run_case("R5 masked update", 2, 1, 80'hBEEF, 40'h0F_A5, 0, 40'h0);
      run_case("R6 count zero", 0, 0, 80'h1, 40'h1, 4, 40'h0);
      run_case("R6 count six", 1, 6, 80'h1, 40'h1, 4, 40'h0);
      run_case("R6 reserved op", 3, 1, 80'h1, 40'h1, 4, 40'h0);
      run_case("R6 update count two", 2, 2, 80'h1, 40'h1, 4, 40'h0);

      pre_busy = 1;
      run_case("R7 mailbox busy", 0, 2, 80'h2222_1111, 40'h77_66, 1, 40'h0);
      pre_busy = 0;

      err_flag = 1;
      run_case("R8 io error on read", 1, 2, 80'h0202_0101, 40'h0, 3, 40'h0);
      err_flag = 0;

      busy_len = 30;
      run_case("R8 slow completion", 0, 2, 80'h0707_0606, 40'h99_88, 0, 40'h0);
      chk(stat_cyc.size() >= 3, "R8 repeated polls", stat_cyc.size(), 3);
      for (int i = 2; i < stat_cyc.size(); i++)
         chk(stat_cyc[i] - stat_cyc[i-1] >= PG, "R8 poll spacing", stat_cyc[i] - stat_cyc[i-1], PG);

      busy_len = 100000;
      run_case("R9 timeout", 1, 1, 80'h0042, 40'h0, 2, 40'h0);
      chk(rsp_cyc - cmd_cyc >= TO, "R9 not before limit", rsp_cyc - cmd_cyc, TO);
      chk(rsp_cyc - cmd_cyc <= TO + PG + 12, "R9 not long after limit", rsp_cyc - cmd_cyc, TO + PG + 12);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule